// File: doc/BRIEF.md
# Dirty Region Update Coalescer

This block walks the per-page dirty flags of a frame buffer once per frame and turns them into screen update rectangles. Each page holds one band of four display lines. The walker asks for one band's flag per cycle, in ascending page order, and merges every unbroken stretch of dirty bands into a single full-width rectangle, given as a first line and a line count. A rectangle is closed when the first clean band after it is seen, or when the walk reaches the display height.

Each rectangle waits at the output under a valid/ready handshake, and the walk pauses until it is taken. While walking, the block tracks the lowest and highest dirty page. When the frame ends it raises a one-cycle done strobe. In that same cycle, if any band was dirty, it requests that the flags be cleared over the page span from the lowest dirty page up to one past the highest. A zero colour depth at the start pulse skips the walk and the clear entirely.

Top module: `dirty_rect_coalescer`

## Requirements
- R1: After reset, `band_req`, `rect_valid`, `clr_valid` and `done` are all low.
- R2: During a walk, `band_req` is high for exactly one cycle per band, with `band_page` counting 0, 1, 2 and up. Page p covers lines 4p to 4p+3. Bands are requested while 4p is below `disp_height`, and `band_dirty` is sampled in the same cycle as the request.
- R3: A stretch of consecutive dirty bands that ends at a clean band yields exactly one rectangle. Its `rect_top` is the first line of the first dirty band, and its `rect_lines` is four times the number of bands in the stretch.
- R4: A stretch still open when the walk ends yields a final rectangle. Its height is the first multiple of four that is not below `disp_height`, minus `rect_top`.
- R5: While `rect_valid` is high and `rect_ready` is low, `rect_top` and `rect_lines` hold steady and no band is requested.
- R6: `done` pulses for one cycle after the last rectangle has been accepted. When any band was dirty, `clr_valid` is high in that same cycle, `clr_lo` is the lowest dirty page, and `clr_hi` is the highest dirty page plus one.
- R7: A frame with no dirty band produces no rectangle, and `clr_valid` stays low.
- R8: A start pulse with `pix_depth` equal to zero requests no band, emits no rectangle, does not raise `clr_valid`, and raises `done` on the cycle right after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a frame walk when idle |
| pix_depth | input | DEPTH_W | Output colour depth; zero skips the frame |
| disp_height | input | LINE_W | Active display height in lines |
| band_req | output | 1 | Flag of `band_page` is being read this cycle |
| band_page | output | LINE_W-1 | Page index of the band under test |
| band_dirty | input | 1 | Dirty flag of `band_page` |
| rect_valid | output | 1 | Update rectangle offered |
| rect_ready | input | 1 | Consumer takes the rectangle |
| rect_top | output | LINE_W | First line of the rectangle |
| rect_lines | output | LINE_W+1 | Line count of the rectangle |
| clr_valid | output | 1 | Clear dirty flags over the page span |
| clr_lo | output | LINE_W-1 | First page to clear |
| clr_hi | output | LINE_W-1 | One past the last page to clear |
| done | output | 1 | Frame finished |

## Verification
Two events can land on the same band: the end-of-walk test and the closing of a still-open dirty stretch. When the final band is dirty, the closing rectangle, the end of the walk and the clear request all follow from one cycle. Directed frames provoke this with the last band dirty, with heights both on and off a multiple of four. Random frames with varying consumer readiness provoke it as well. The final rectangle's height is judged against the padded end line, and the bench checks that `done` and the clear span appear only after that rectangle has been taken.

// File: rtl/coal_pkg.sv
package coal_pkg;
    localparam int BAND_LINES = 4;
    localparam int BAND_SHIFT = 2;

    typedef enum logic [1:0] {
        CO_IDLE,
        CO_SCAN,
        CO_HOLD,
        CO_FIN
    } co_state_e;

    // line count from a stretch's first line up to the current walk line
    function automatic int unsigned span_lines(input int unsigned cur_line,
                                               input int unsigned first_line);
        return cur_line - first_line;
    endfunction
endpackage

// File: rtl/coal_band_cursor.sv
module coal_band_cursor
    import coal_pkg::*;
#(
    parameter int CNT_W  = 13,
    parameter int PAGE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    output logic [CNT_W-1:0]  line,
    output logic [PAGE_W-1:0] page
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            line <= '0;
            page <= '0;
        end else if (step) begin
            line <= line + CNT_W'(BAND_LINES);
            page <= page + PAGE_W'(1);
        end
    end

    // line counter and page counter move in lock step (R2)
    assert_line_page_lock_R2: assert property (@(posedge clk) disable iff (rst)
        line == {page, 2'b00});
endmodule

// File: rtl/coal_extent_track.sv
module coal_extent_track #(
    parameter int PAGE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              hit,
    input  logic [PAGE_W-1:0] page,
    output logic [PAGE_W-1:0] lo,
    output logic [PAGE_W-1:0] hi,
    output logic              any
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            lo  <= '1;
            hi  <= '0;
            any <= 1'b0;
        end else if (hit) begin
            if (page < lo) lo <= page;
            if (!any || page > hi) hi <= page;
            any <= 1'b1;
        end
    end

    assert_extent_order_R6: assert property (@(posedge clk) disable iff (rst)
        any |-> lo <= hi);
    assert_extent_empty_R7: assert property (@(posedge clk) disable iff (rst)
        !any |-> lo == '1);
endmodule

// File: rtl/coal_rect_hold.sv
module coal_rect_hold #(
    parameter int LINE_W = 12,
    parameter int CNT_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [LINE_W-1:0] top_in,
    input  logic [CNT_W-1:0]  lines_in,
    input  logic              ready,
    output logic              valid,
    output logic [LINE_W-1:0] top,
    output logic [CNT_W-1:0]  lines
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            top   <= '0;
            lines <= '0;
        end else if (load) begin
            valid <= 1'b1;
            top   <= top_in;
            lines <= lines_in;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end

    assert_rect_hold_R5: assert property (@(posedge clk) disable iff (rst)
        valid && !ready |=> valid && $stable(top) && $stable(lines));
    assert_rect_shape_R3: assert property (@(posedge clk) disable iff (rst)
        valid |-> (lines != '0) && (lines[1:0] == 2'b00));
endmodule

// File: rtl/dirty_rect_coalescer.sv
module dirty_rect_coalescer
    import coal_pkg::*;
#(
    parameter int LINE_W  = 12,
    parameter int DEPTH_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [DEPTH_W-1:0] pix_depth,
    input  logic [LINE_W-1:0]  disp_height,
    output logic               band_req,
    output logic [LINE_W-2:0]  band_page,
    input  logic               band_dirty,
    output logic               rect_valid,
    input  logic               rect_ready,
    output logic [LINE_W-1:0]  rect_top,
    output logic [LINE_W:0]    rect_lines,
    output logic               clr_valid,
    output logic [LINE_W-2:0]  clr_lo,
    output logic [LINE_W-2:0]  clr_hi,
    output logic               done
);
    localparam int CNT_W  = LINE_W + 1;
    localparam int PAGE_W = CNT_W - BAND_SHIFT;

    co_state_e            state;
    logic                 run_open;
    logic [LINE_W-1:0]    run_top;
    logic                 ret_fin;

    logic [CNT_W-1:0]     line;
    logic [PAGE_W-1:0]    page;
    logic [PAGE_W-1:0]    ext_lo, ext_hi;
    logic                 ext_any;

    logic                 frame_go, scan_end, step, hit, flush;
    logic [CNT_W-1:0]     flush_lines;

    assign frame_go = (state == CO_IDLE) && start;
    assign scan_end = line >= {1'b0, disp_height};
    assign step     = (state == CO_SCAN) && !scan_end;
    assign hit      = step && band_dirty;
    assign flush    = (state == CO_SCAN) && run_open && (scan_end || !band_dirty);
    assign flush_lines = CNT_W'(span_lines(int'(line), int'(run_top)));

    coal_band_cursor #(.CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_cursor (
        .clk(clk), .rst(rst), .clear(frame_go), .step(step),
        .line(line), .page(page)
    );

    coal_extent_track #(.PAGE_W(PAGE_W)) u_extent (
        .clk(clk), .rst(rst), .clear(frame_go), .hit(hit), .page(page),
        .lo(ext_lo), .hi(ext_hi), .any(ext_any)
    );

    coal_rect_hold #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_hold (
        .clk(clk), .rst(rst), .load(flush), .top_in(run_top),
        .lines_in(flush_lines), .ready(rect_ready),
        .valid(rect_valid), .top(rect_top), .lines(rect_lines)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= CO_IDLE;
            run_open <= 1'b0;
            run_top  <= '0;
            ret_fin  <= 1'b0;
        end else begin
            case (state)
                CO_IDLE: begin
                    if (start) begin
                        run_open <= 1'b0;
                        state    <= (pix_depth == '0) ? CO_FIN : CO_SCAN;
                    end
                end
                CO_SCAN: begin
                    if (hit && !run_open) begin
                        run_open <= 1'b1;
                        run_top  <= line[LINE_W-1:0];
                    end
                    if (flush) begin
                        run_open <= 1'b0;
                        ret_fin  <= scan_end;
                        state    <= CO_HOLD;
                    end else if (scan_end) begin
                        state <= CO_FIN;
                    end
                end
                CO_HOLD: begin
                    if (rect_valid && rect_ready)
                        state <= ret_fin ? CO_FIN : CO_SCAN;
                end
                default: state <= CO_IDLE;
            endcase
        end
    end

    assign band_req  = step;
    assign band_page = page;
    assign done      = (state == CO_FIN);
    assign clr_valid = done && ext_any;
    assign clr_lo    = ext_lo;
    assign clr_hi    = ext_hi + PAGE_W'(1);

    assert_no_fetch_while_pending_R5: assert property (@(posedge clk) disable iff (rst)
        !(band_req && rect_valid));
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_clear_with_done_R6: assert property (@(posedge clk) disable iff (rst)
        clr_valid |-> done && !rect_valid);
    assert_zero_depth_skip_R8: assert property (@(posedge clk) disable iff (rst)
        (state == CO_IDLE && start && pix_depth == '0) |=> done && !clr_valid);
endmodule

// File: tb/tb_dirty_rect_coalescer.sv
module tb_dirty_rect_coalescer;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_W = 12;
    localparam int DEPTH_W = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [DEPTH_W-1:0] pix_depth = '0;
    logic [LINE_W-1:0] disp_height = '0;
    logic band_req, rect_valid, clr_valid, done;
    logic [LINE_W-2:0] band_page, clr_lo, clr_hi;
    logic rect_ready = 1'b0;
    logic [LINE_W-1:0] rect_top;
    logic [LINE_W:0] rect_lines;
    logic [63:0] dv = '0;
    logic band_dirty;

    assign band_dirty = dv[band_page[5:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    dirty_rect_coalescer #(.LINE_W(LINE_W), .DEPTH_W(DEPTH_W)) dut (
        .clk(clk), .rst(rst), .start(start), .pix_depth(pix_depth),
        .disp_height(disp_height), .band_req(band_req), .band_page(band_page),
        .band_dirty(band_dirty), .rect_valid(rect_valid), .rect_ready(rect_ready),
        .rect_top(rect_top), .rect_lines(rect_lines), .clr_valid(clr_valid),
        .clr_lo(clr_lo), .clr_hi(clr_hi), .done(done)
    );

    int n_chk = 0;
    int n_bad = 0;

    int exp_top [64];
    int exp_len [64];
    bit exp_end [64];
    int exp_n, exp_lo, exp_hi, exp_bands;
    bit exp_any;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic void model(input int h, input logic [63:0] v);
        int ln, pg, st;
        bit open;
        exp_n = 0; exp_any = 0; exp_lo = -1; exp_hi = -1;
        open = 0; st = 0; ln = 0; pg = 0;
        while (ln < h) begin
            if (v[pg]) begin
                if (!open) begin open = 1; st = ln; end
                if (!exp_any) exp_lo = pg;
                exp_hi = pg;
                exp_any = 1;
            end else if (open) begin
                exp_top[exp_n] = st; exp_len[exp_n] = ln - st; exp_end[exp_n] = 0;
                exp_n++; open = 0;
            end
            ln += 4; pg++;
        end
        if (open) begin
            exp_top[exp_n] = st; exp_len[exp_n] = ln - st; exp_end[exp_n] = 1;
            exp_n++;
        end
        exp_bands = pg;
    endfunction

    task automatic run_frame(input int h, input logic [63:0] v, input bit dz, input int pct);
        int got, pg, pgbad, fetch_hold, stab, cyc, ptop, plines;
        bit prev_hold, act;
        model(h, v);
        dv = v;
        disp_height = LINE_W'(h);
        pix_depth = dz ? '0 : DEPTH_W'(24);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        got = 0; pg = 0; pgbad = 0; fetch_hold = 0; stab = 0; cyc = 0;
        prev_hold = 0; act = 0; ptop = 0; plines = 0;
        forever begin
            if (done) break;
            if (band_req) begin
                act = 1;
                if (int'(band_page) != pg) pgbad++;
                pg++;
            end
            if (rect_valid) begin
                act = 1;
                if (band_req) fetch_hold++;
                if (prev_hold && (int'(rect_top) != ptop || int'(rect_lines) != plines)) stab++;
            end else if (prev_hold) begin
                stab++;
            end
            rect_ready = (($urandom % 100) < pct);
            if (rect_valid && rect_ready) begin
                if (got < exp_n) begin
                    if (exp_end[got]) begin
                        check(int'(rect_top) == exp_top[got], "R4 top", int'(rect_top), exp_top[got]);
                        check(int'(rect_lines) == exp_len[got], "R4 lines", int'(rect_lines), exp_len[got]);
                    end else begin
                        check(int'(rect_top) == exp_top[got], "R3 top", int'(rect_top), exp_top[got]);
                        check(int'(rect_lines) == exp_len[got], "R3 lines", int'(rect_lines), exp_len[got]);
                    end
                end
                got++;
                prev_hold = 0;
            end else begin
                prev_hold = rect_valid;
                ptop = int'(rect_top);
                plines = int'(rect_lines);
            end
            cyc++;
            if (cyc > 5000) break;
            @(negedge clk);
        end
        rect_ready = 1'b0;
        check(done == 1'b1, "R6 done reached", int'(done), 1);
        if (dz) begin
            check(cyc == 0, "R8 done latency", cyc, 0);
            check(!act, "R8 no activity", int'(act), 0);
            check(clr_valid == 1'b0, "R8 no clear", int'(clr_valid), 0);
        end else begin
            check(pgbad == 0 && pg == exp_bands, "R2 band walk", pg, exp_bands);
            check(got == exp_n, "R3 rect count", got, exp_n);
            check(stab == 0 && fetch_hold == 0, "R5 hold while stalled", stab + fetch_hold, 0);
            if (exp_any) begin
                check(clr_valid == 1'b1, "R6 clear valid", int'(clr_valid), 1);
                check(int'(clr_lo) == exp_lo, "R6 clear lo", int'(clr_lo), exp_lo);
                check(int'(clr_hi) == exp_hi + 1, "R6 clear hi", int'(clr_hi), exp_hi + 1);
            end else begin
                check(clr_valid == 1'b0, "R7 no clear", int'(clr_valid), 0);
                check(got == 0, "R7 no rect", got, 0);
            end
        end
        @(negedge clk);
        check(done == 1'b0, "R6 done one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog all-R actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!band_req && !rect_valid && !clr_valid && !done, "R1 reset idle",
              int'({band_req, rect_valid, clr_valid, done}), 0);

        run_frame(64, 64'h0, 0, 100);                    // R7 all clean
        run_frame(64, 64'hFFFF, 0, 100);                 // R4 all dirty
        run_frame(62, 64'h8000, 0, 50);                  // R4 last band dirty, odd height
        run_frame(64, 64'h8001, 0, 30);                  // R3 first and R4 last
        run_frame(64, 64'h5555, 0, 40);                  // R3 alternating
        run_frame(40, 64'h0F0, 0, 25);                   // R3 mid stretch
        run_frame(0, 64'hFF, 0, 100);                    // zero height
        run_frame(64, 64'hFFFF, 1, 100);                 // R8 zero depth
        run_frame(255, {64{1'b1}}, 0, 60);               // R4 full height
        for (int i = 0; i < 40; i++) begin
            logic [63:0] v;
            int h, pct;
            v = {$urandom, $urandom};
            if (i % 3 == 0) v = v & {$urandom, $urandom};
            if (i % 3 == 1) v = v | {$urandom, $urandom};
            h = $urandom % 256;
            pct = 20 + ($urandom % 81);
            run_frame(h, v, (i % 10 == 9), pct);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule